// File: doc/BRIEF.md
# Streaming and Looping Waveform Output Sequencer

This block feeds sample words to the converters of one group of analog output channels at a rate chosen for that group. A cycle-count divider produces update ticks, and every tick raises a one-cycle load strobe toward the converter. The data that goes with the strobe comes from one of two sources.

In streaming mode, each tick takes one word from an upstream FIFO through a valid/ready pair and presents it. If the FIFO has nothing on a tick, the previous word is held and a sticky underflow flag is raised. In looping mode, the host first fills a local waveform memory through a simple write port and sets the index of the last sample to use. The block then steps through the stored samples on every tick and wraps back to the first, with no further traffic from the host. The source mode is only taken while the group is stopped, so a running waveform can never switch sources partway through.

Top module: `wave_out_sequencer`

## Requirements
- R1: After reset, `dac_data` is 0, `dac_load` is 0, `underflow` is 0 and `s_ready` is 0.
- R2: While `run` stays high, `dac_load` pulses once every `div_cfg`+1 clock cycles. The first pulse is visible `div_cfg`+1 cycles after the first clock edge that samples `run` high.
- R3: When `div_cfg` is nonzero, `dac_load` is never high in two consecutive cycles.
- R4: In streaming mode (`mode_regen`=0), a tick with `s_valid` high drives `s_ready` high and consumes one word. That word appears on `dac_data` together with the strobe, and words come out in arrival order.
- R5: In streaming mode, a tick with `s_valid` low still pulses `dac_load`, keeps the previous `dac_data`, and sets `underflow`.
- R6: `underflow` stays set until the first clock edge that samples `run` high after it was low. That edge clears it, unless an underflow occurs on the same edge.
- R7: A write with `wr_en` high stores `wr_data` at `wr_addr`, and the stored word is used by later looping playback.
- R8: In looping mode (`mode_regen`=1), successive strobes present memory words 0, 1, …, `loop_last`, then 0 again, repeating. Every new start begins at word 0.
- R9: `mode_regen` is sampled only while `run` is low. A change while running has no effect on the data source.
- R10: In looping mode, `s_ready` stays low and no stream word is consumed.
- R11: No `dac_load` pulse is produced while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Group running when high |
| mode_regen | input | 1 | Source select: 0 stream, 1 looping memory |
| div_cfg | input | DIV_W | Update period minus one, in clock cycles |
| loop_last | input | ADDR_W | Index of the last stored sample in the loop |
| wr_en | input | 1 | Waveform memory write enable |
| wr_addr | input | ADDR_W | Waveform memory write address |
| wr_data | input | DATA_W | Waveform memory write data |
| s_valid | input | 1 | Stream word available |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Stream word taken on this edge |
| dac_data | output | DATA_W | Sample word to the converter |
| dac_load | output | 1 | One-cycle converter load strobe |
| underflow | output | 1 | Sticky stream underflow flag |

## Verification
The in-module assertions run every cycle and cover the properties that depend only on neighbouring cycles. These are: the mode freeze while running, `s_ready` staying low in looping mode, no strobe after a stopped cycle, single-cycle strobes for a nonzero divider, the data hold when underflow rises, flag stickiness, and the playback index returning to zero while stopped. Only the bench scenarios can show the properties that span many cycles or depend on content. These include the exact strobe spacing for several divider values, stream words leaving in order without loss, the wrap sequence through memory across several loops, a memory rewrite appearing on the next run, and the flag clearing on restart.

// File: rtl/wave_out_sequencer.sv
module wave_out_sequencer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mode_regen,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [ADDR_W-1:0] loop_last,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_load,
  output logic              underflow
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DIV_W-1:0]  cnt;
  logic              regen_q;
  logic              run_d;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] mem [DEPTH];

  wire tick  = run && (cnt >= div_cfg);
  wire start = run && !run_d;
  assign s_ready = tick && !regen_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (!run || tick)     cnt <= '0;
    else                       cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      regen_q <= 1'b0;
      run_d   <= 1'b0;
    end else begin
      run_d <= run;
      if (!run) regen_q <= mode_regen;
    end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                rd_addr <= '0;
    else if (!run)             rd_addr <= '0;
    else if (tick && regen_q)  rd_addr <= (rd_addr == loop_last) ? '0 : rd_addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dac_data <= '0;
      dac_load <= 1'b0;
    end else begin
      dac_load <= tick;
      if (tick) begin
        if (regen_q)      dac_data <= mem[rd_addr];
        else if (s_valid) dac_data <= s_data;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            underflow <= 1'b0;
    else if (tick && !regen_q && !s_valid) underflow <= 1'b1;
    else if (start)                        underflow <= 1'b0;

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(regen_q));
  p_ready_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !regen_q);
  p_no_load_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !dac_load);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load && (div_cfg != '0) |=> !dac_load);
  p_hold_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $stable(dac_data));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(underflow) && !$past(start) |-> underflow);
  p_addr_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> rd_addr == '0);
endmodule

// File: tb/tb_wave_out_sequencer.sv
module tb_wave_out_sequencer;
  localparam int DATA_W = 16, ADDR_W = 5, DIV_W = 16;

  logic clk = 0, rst_n = 0, run = 0, mode_regen = 0, wr_en = 0, s_valid = 0;
  logic [DIV_W-1:0]  div_cfg = 3;
  logic [ADDR_W-1:0] loop_last = 0, wr_addr = 0;
  logic [DATA_W-1:0] wr_data = 0, s_data = 0;
  logic              s_ready, dac_load, underflow;
  logic [DATA_W-1:0] dac_data;

  int checks = 0, errors = 0;
  string cur_req = "R4";
  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] src_q[$];
  logic [DATA_W-1:0] mem_m[5];
  bit take = 0;

  wave_out_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_regen(mode_regen), .div_cfg(div_cfg),
    .loop_last(loop_last), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .dac_data(dac_data),
    .dac_load(dac_load), .underflow(underflow));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // stream source model: consumption seen at the edge, queue updated at the next negedge
  always @(posedge clk) take = s_ready && s_valid;
  always @(negedge clk) begin
    if (take) begin
      void'(src_q.pop_front());
      take = 0;
    end
    s_valid = (src_q.size() > 0);
    s_data  = (src_q.size() > 0) ? src_q[0] : '0;
  end

  // scoreboard monitor
  always @(negedge clk)
    if (rst_n && dac_load) begin
      if (exp_q.size() == 0) chk("R11 unexpected strobe", 1, 0);
      else chk(cur_req, dac_data, exp_q.pop_front());
    end

  task automatic run_ticks(int n, int toggle_at);
    int k = 0, gap = 0;
    bit prev = 0;
    run = 1;
    while (k < n) begin
      @(negedge clk);
      gap++;
      if (prev && dac_load && div_cfg != 0) chk("R3", 1, 0);
      prev = dac_load;
      if (dac_load) begin
        k++;
        chk("R2", gap, int'(div_cfg) + 1);
        gap = 0;
        if (k == toggle_at) mode_regen = ~mode_regen;
      end
    end
    run = 0;
  endtask

  task automatic write_mem(int a, logic [DATA_W-1:0] d);
    wr_en = 1; wr_addr = a[ADDR_W-1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dac_data", dac_data, 0);
    chk("R1 dac_load", dac_load, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 s_ready", s_ready, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // streaming, divider 3
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      src_q.push_back(16'hA000 + 16'(i));
      exp_q.push_back(16'hA000 + 16'(i));
    end
    repeat (2) @(negedge clk);
    run_ticks(6, 0);
    repeat (2) @(negedge clk);
    chk("R4 all consumed", src_q.size(), 0);
    chk("R4 no underflow", underflow, 0);

    // streaming at full rate, then underflow
    div_cfg = 0;
    cur_req = "R5";
    for (int i = 0; i < 4; i++) begin
      src_q.push_back(16'h5500 + 16'(i));
      exp_q.push_back(16'h5500 + 16'(i));
    end
    exp_q.push_back(16'h5503);
    exp_q.push_back(16'h5503);
    repeat (2) @(negedge clk);
    run_ticks(6, 0);
    @(negedge clk);
    chk("R5 flag", underflow, 1);
    repeat (6) @(negedge clk);
    chk("R6 sticky", underflow, 1);
    chk("R11 no pending", exp_q.size(), 0);

    // restart clears the flag
    div_cfg = 2;
    cur_req = "R6";
    src_q.push_back(16'h0777);
    exp_q.push_back(16'h0777);
    repeat (2) @(negedge clk);
    run_ticks(1, 0);
    chk("R6 cleared", underflow, 0);
    repeat (3) @(negedge clk);

    // looping playback
    for (int i = 0; i < 5; i++) begin
      mem_m[i] = 16'h1000 + 16'(i * 3);
      write_mem(i, mem_m[i]);
    end
    loop_last = 4;
    mode_regen = 1;
    div_cfg = 1;
    for (int i = 0; i < 4; i++) src_q.push_back(16'hB000 + 16'(i));
    repeat (2) @(negedge clk);
    cur_req = "R8/R9";
    for (int i = 0; i < 12; i++) exp_q.push_back(mem_m[i % 5]);
    run_ticks(12, 3);
    repeat (2) @(negedge clk);
    chk("R10 stream untouched", src_q.size(), 4);
    chk("R10 no underflow", underflow, 0);
    mode_regen = 1;
    mem_m[1] = 16'hCAFE;
    write_mem(1, mem_m[1]);
    @(negedge clk);
    cur_req = "R7/R8 restart";
    exp_q.push_back(mem_m[0]);
    exp_q.push_back(mem_m[1]);
    exp_q.push_back(mem_m[2]);
    run_ticks(3, 0);
    repeat (2) @(negedge clk);

    // back to streaming: queued words drain in order
    mode_regen = 0;
    @(negedge clk);
    div_cfg = 4;
    cur_req = "R4 after mode change";
    for (int i = 0; i < 4; i++) exp_q.push_back(16'hB000 + 16'(i));
    run_ticks(4, 0);
    repeat (10) @(negedge clk);
    chk("R4 drained", src_q.size(), 0);
    chk("R11 none pending", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule